// File: doc/BRIEF.md
# Masked Interrupt Aggregator with Software Trigger

This block collects up to 32 interrupt event lines for one destination processor. Each hardware event pulse latches a sticky pending bit. A mask register decides which pending bits reach the single interrupt request line. Software reaches the block through a small register port with one write channel and one read channel. The mask and the pending bits are never written directly. They change only through write-one aliases: set-mask, clear-mask, clear-pending, acknowledge and software trigger. A zero bit in any of these writes leaves the matching state bit alone.

A pending bit can be cleared in the same cycle that a new event arrives on its source. In that case the event takes priority and the bit stays pending, so the event is not lost. The software trigger sets pending bits exactly as a hardware event does and holds no state of its own. Reads are combinational and change nothing.

Register offsets, each holding a 32-bit word: 0 mask (read only), 1 set-mask, 2 clear-mask, 3 clear-pending, 4 acknowledge, 5 software trigger, 6 masked pending (read only), 7 raw pending (read only).

Top module: `irq_aggregator`

## Requirements
- R1: In the clock cycle after a clock edge with rst_n low, the mask reads all ones at offset 0, raw pending reads 0 at offset 7, and irq is 0.
- R2: A write to offset 1 sets every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R3: A write to offset 2 clears every mask bit whose data bit is 1. Mask bits whose data bit is 0 keep their value.
- R4: A one-cycle pulse on src_evt[i] sets raw pending bit i on the next clock edge. The bit then stays set until software clears it.
- R5: A write to offset 3 clears every pending bit whose data bit is 1. Bits whose data bit is 0 are left pending.
- R6: A write to offset 4 (acknowledge) clears pending bits in the same way as offset 3.
- R7: If src_evt[i] is high in the same cycle as a clear of bit i (offset 3 or 4), bit i stays pending.
- R8: A write to offset 5 sets every pending bit whose data bit is 1, as a hardware event would. Offset 5 always reads 0, and so do offsets 1 to 4.
- R9: Offset 7 shows all pending bits whatever the mask. Offset 6 shows pending bits whose mask bit is 0.
- R10: irq is high exactly when at least one bit of the masked pending set is 1.
- R11: Reading any offset leaves the mask and the pending bits unchanged.
- R12: Writes to offsets 0, 6 and 7 change neither the mask nor the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_evt | input | 32 | Hardware event pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read offset |
| rd_data | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt request to the destination |

## Verification
The mask aliases are tested with bit patterns that overlap the current mask only in part, so a direct write can be told apart from a true set or clear alias. Events arrive both on masked and on unmasked sources, which separates the raw view from the masked view and shows when irq must stay low. A clear-pending write that also covers a source with a coincident event checks that the event wins, and the bench then walks a single event across every source, once with the mask closed and once with it open. The read offset moves every cycle, so repeated reads show that reading has no side effects.

// File: rtl/irqagg_pkg.sv
// Shared definitions for the interrupt aggregator.
// Assumes a fixed map of eight word registers, so three address bits.
package irqagg_pkg;

    localparam int REG_AW = 3;

    // Register offsets; the order is a layout choice only.
    typedef enum logic [REG_AW-1:0] {
        RA_MASK      = 3'd0,
        RA_MASK_SET  = 3'd1,
        RA_MASK_CLR  = 3'd2,
        RA_PEND_CLR  = 3'd3,
        RA_ACK       = 3'd4,
        RA_SWTRIG    = 3'd5,
        RA_MASKED    = 3'd6,
        RA_RAW       = 3'd7
    } reg_addr_e;

    // One-hot write intents decoded from a register write.
    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic pend_clr;
        logic swtrig;
    } wr_strobe_t;

endpackage

// File: rtl/irqagg_regdec.sv
// Write decoder: turns a register write into per-function bit vectors.
// Assumes at most one write per cycle; read-only offsets decode to nothing.
module irqagg_regdec #(
    parameter int NSRC = 32
) (
    input  logic                            wr_en,
    input  logic [irqagg_pkg::REG_AW-1:0]   wr_addr,
    input  logic [NSRC-1:0]                 wr_data,
    output logic [NSRC-1:0]                 set_mask_v,
    output logic [NSRC-1:0]                 clr_mask_v,
    output logic [NSRC-1:0]                 clr_pend_v,
    output logic [NSRC-1:0]                 trig_v
);
    import irqagg_pkg::*;

    wr_strobe_t stb;

    // Decode the write offset into one strobe per alias.
    always_comb begin
        stb = '0;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_MASK_SET: stb.mask_set = 1'b1;
                RA_MASK_CLR: stb.mask_clr = 1'b1;
                RA_PEND_CLR,
                RA_ACK:      stb.pend_clr = 1'b1;
                RA_SWTRIG:   stb.swtrig   = 1'b1;
                default:     stb = '0;
            endcase
        end
    end

    // Gate the write data by each strobe to form per-bit commands.
    always_comb begin
        set_mask_v = stb.mask_set ? wr_data : '0;
        clr_mask_v = stb.mask_clr ? wr_data : '0;
        clr_pend_v = stb.pend_clr ? wr_data : '0;
        trig_v     = stb.swtrig   ? wr_data : '0;
    end

endmodule

// File: rtl/irqagg_mask_reg.sv
// Mask register, changed only by write-one set and clear vectors.
// A bit of 1 blocks its source. Assumes set and clear never overlap in a cycle.
module irqagg_mask_reg #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_v,
    input  logic [NSRC-1:0] clr_v,
    output logic [NSRC-1:0] mask_q
);

    // Hold the mask; reset blocks every source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else begin
            mask_q <= (mask_q | set_v) & ~clr_v;
        end
    end

endmodule

// File: rtl/irqagg_status_bank.sv
// Sticky pending bits, one cell per source.
// A hardware event or a software trigger sets a bit; a clear resets it.
// When a set and a clear meet in one cycle, the set takes priority.
module irqagg_status_bank #(
    parameter int NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_v,
    input  logic [NSRC-1:0] trig_v,
    input  logic [NSRC-1:0] clr_v,
    output logic [NSRC-1:0] raw_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_cell
        // Update one pending bit; a set outranks a clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raw_q[i] <= 1'b0;
            end else if (evt_v[i] || trig_v[i]) begin
                raw_q[i] <= 1'b1;
            end else if (clr_v[i]) begin
                raw_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irqagg_readmux.sv
// Read port: selects one register view by offset, with no side effects.
// The write-only aliases read back as zero.
module irqagg_readmux #(
    parameter int NSRC = 32
) (
    input  logic [irqagg_pkg::REG_AW-1:0]   rd_addr,
    input  logic [NSRC-1:0]                 mask_q,
    input  logic [NSRC-1:0]                 masked_v,
    input  logic [NSRC-1:0]                 raw_q,
    output logic [NSRC-1:0]                 rd_data
);
    import irqagg_pkg::*;

    // Select the read view for the requested offset.
    always_comb begin
        case (reg_addr_e'(rd_addr))
            RA_MASK:   rd_data = mask_q;
            RA_MASKED: rd_data = masked_v;
            RA_RAW:    rd_data = raw_q;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/irq_aggregator.sv
// Interrupt aggregator top: write decode, mask, pending bank and read mux.
// Assumes src_evt carries single-cycle pulses, already synchronous to clk.
module irq_aggregator #(
    parameter int NSRC = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NSRC-1:0]                 src_evt,
    input  logic                            wr_en,
    input  logic [irqagg_pkg::REG_AW-1:0]   wr_addr,
    input  logic [NSRC-1:0]                 wr_data,
    input  logic [irqagg_pkg::REG_AW-1:0]   rd_addr,
    output logic [NSRC-1:0]                 rd_data,
    output logic                            irq
);

    logic [NSRC-1:0] set_mask_v;
    logic [NSRC-1:0] clr_mask_v;
    logic [NSRC-1:0] clr_pend_v;
    logic [NSRC-1:0] trig_v;
    logic [NSRC-1:0] mask_q;
    logic [NSRC-1:0] raw_q;
    logic [NSRC-1:0] masked_v;

    irqagg_regdec #(.NSRC(NSRC)) u_dec (
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .set_mask_v (set_mask_v),
        .clr_mask_v (clr_mask_v),
        .clr_pend_v (clr_pend_v),
        .trig_v     (trig_v)
    );

    irqagg_mask_reg #(.NSRC(NSRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_v  (set_mask_v),
        .clr_v  (clr_mask_v),
        .mask_q (mask_q)
    );

    irqagg_status_bank #(.NSRC(NSRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_v  (src_evt),
        .trig_v (trig_v),
        .clr_v  (clr_pend_v),
        .raw_q  (raw_q)
    );

    // Combine the pending bits with the mask and reduce them to the request line.
    always_comb begin
        masked_v = raw_q & ~mask_q;
        irq      = |masked_v;
    end

    irqagg_readmux #(.NSRC(NSRC)) u_rd (
        .rd_addr  (rd_addr),
        .mask_q   (mask_q),
        .masked_v (masked_v),
        .raw_q    (raw_q),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/irqagg_chk.sv
// Property checker for the interrupt aggregator, attached by bind.
module irqagg_chk #(
    parameter int NSRC = 32
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [NSRC-1:0]                 src_evt,
    input logic                            wr_en,
    input logic [irqagg_pkg::REG_AW-1:0]   wr_addr,
    input logic [NSRC-1:0]                 wr_data,
    input logic                            irq,
    input logic [NSRC-1:0]                 raw_q,
    input logic [NSRC-1:0]                 mask_q
);
    import irqagg_pkg::*;

    logic any_clr;
    logic mask_wr;
    assign any_clr = wr_en && (wr_addr == RA_PEND_CLR || wr_addr == RA_ACK);
    assign mask_wr = wr_en && (wr_addr == RA_MASK_SET || wr_addr == RA_MASK_CLR);

    p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_MASK_SET) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

    p_mask_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_MASK_CLR) |=> ((mask_q & $past(wr_data)) == '0));

    p_event_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt != '0) |=> ((raw_q & $past(src_evt)) == $past(src_evt)));

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !any_clr |=> (($past(raw_q) & ~raw_q) == '0));

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_clr |=> ((raw_q & $past(wr_data & ~src_evt)) == '0));

    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_clr && ((wr_data & src_evt) != '0))
            |=> ((raw_q & $past(wr_data & src_evt)) == $past(wr_data & src_evt)));

    p_trigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == RA_SWTRIG) |=> ((raw_q & $past(wr_data)) == $past(wr_data)));

    p_irq_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((raw_q & ~mask_q) != '0));

    p_mask_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_wr |=> $stable(mask_q));

endmodule

bind irq_aggregator irqagg_chk #(.NSRC(NSRC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_evt (src_evt),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .irq     (irq),
    .raw_q   (raw_q),
    .mask_q  (mask_q)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;

    localparam int N = 32;
    // Offsets as stated in the requirements.
    localparam logic [2:0] O_MASK = 3'd0, O_SET = 3'd1, O_CLR = 3'd2, O_PCLR = 3'd3,
                           O_ACK = 3'd4, O_TRIG = 3'd5, O_MSKD = 3'd6, O_RAW = 3'd7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src_evt = '0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [N-1:0]  wr_data = '0;
    logic [2:0]    rd_addr = '0;
    logic [N-1:0]  rd_data;
    logic          irq;

    int     n_vec = 0;
    int     n_bad = 0;
    bit     chk_on = 1'b0;
    bit     done = 1'b0;
    string  tag = "R1";
    logic [N-1:0] m_mask;
    logic [N-1:0] m_raw;
    int     rd_ptr = 0;

    irq_aggregator #(.NSRC(N)) uut (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .irq(irq)
    );

    always #2 clk = ~clk;

    // Reference model: behavioural per-bit update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = '1;
            m_raw  = '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                bit set_p, clr_p;
                set_p = src_evt[i] || (wr_en && wr_addr == O_TRIG && wr_data[i]);
                clr_p = wr_en && (wr_addr == O_PCLR || wr_addr == O_ACK) && wr_data[i];
                if (set_p)      m_raw[i] = 1'b1;
                else if (clr_p) m_raw[i] = 1'b0;
                if (wr_en && wr_addr == O_SET && wr_data[i]) m_mask[i] = 1'b1;
                if (wr_en && wr_addr == O_CLR && wr_data[i]) m_mask[i] = 1'b0;
            end
            chk_on = 1'b1;
        end
        if (!rst_n) chk_on = 1'b1;
    end

    function automatic logic [N-1:0] expect_rd(input logic [2:0] a);
        case (a)
            O_MASK: return m_mask;
            O_MSKD: return m_raw & ~m_mask;
            O_RAW:  return m_raw;
            default: return '0;
        endcase
    endfunction

    // Compare outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (chk_on && !done) begin
            logic [N-1:0] exp_d;
            logic         exp_i;
            exp_d = expect_rd(rd_addr);
            exp_i = |(m_raw & ~m_mask);
            n_vec++;
            if (rd_data !== exp_d) begin
                n_bad++;
                $display("FAIL %s: rd_data at offset %0d = %h, expected %h", tag, rd_addr, rd_data, exp_d);
            end
            n_vec++;
            if (irq !== exp_i) begin
                n_bad++;
                $display("FAIL R10 (phase %s): irq = %b, expected %b", tag, irq, exp_i);
            end
        end
    end

    // Drive one cycle of stimulus just after the falling edge.
    task automatic cyc(input logic we, input logic [2:0] a, input logic [N-1:0] d,
                       input logic [N-1:0] ev);
        @(negedge clk);
        #1;
        wr_en   = we;
        wr_addr = a;
        wr_data = d;
        src_evt = ev;
        rd_addr = 3'(rd_ptr);
        rd_ptr  = (rd_ptr + 1) % 8;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(1'b0, O_MASK, '0, '0);
    endtask

    initial begin
        tag = "R1";
        idle(3);
        @(negedge clk); #1 rst_n = 1'b1;
        idle(8);
        tag = "R3";
        cyc(1'b1, O_CLR, 32'h0000_FFFF, '0); idle(8);
        tag = "R2";
        cyc(1'b1, O_SET, 32'h0000_0F0F, '0); cyc(1'b1, O_SET, '0, '0); idle(8);
        tag = "R12";
        cyc(1'b1, O_MASK, '0, '0); cyc(1'b1, O_MSKD, '1, '0); cyc(1'b1, O_RAW, '1, '0); idle(8);
        tag = "R4";
        cyc(1'b0, O_MASK, '0, 32'h0000_00F0); idle(8);
        tag = "R9";
        cyc(1'b0, O_MASK, '0, 32'h8000_0001); idle(8);
        tag = "R5";
        cyc(1'b1, O_PCLR, 32'h0000_0030, '0); cyc(1'b1, O_PCLR, '0, '0); idle(8);
        tag = "R6";
        cyc(1'b1, O_ACK, 32'h0000_00C0, '0); idle(8);
        tag = "R7";
        cyc(1'b1, O_PCLR, 32'h8000_0001, 32'h8000_0000); idle(8);
        cyc(1'b1, O_ACK, 32'h0000_0400, 32'h0000_0400); idle(8);
        tag = "R8";
        cyc(1'b1, O_TRIG, 32'h0000_1000, '0); cyc(1'b1, O_TRIG, '0, '0); idle(8);
        tag = "R11";
        idle(16);
        tag = "R9";
        cyc(1'b1, O_PCLR, '1, '0); cyc(1'b1, O_SET, '1, '0);
        for (int i = 0; i < N; i++) begin
            cyc(1'b0, O_MASK, '0, 32'(1) << i); idle(1);
        end
        idle(8);
        tag = "R10";
        cyc(1'b1, O_PCLR, '1, '0); cyc(1'b1, O_CLR, '1, '0);
        for (int i = 0; i < N; i++) begin
            cyc(1'b0, O_MASK, '0, 32'(1) << i); idle(1);
            cyc(1'b1, O_ACK, 32'(1) << i, '0); idle(1);
        end
        idle(8);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(4 * 20000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule